// File: doc/BRIEF.md
# Bit-Field Clear, Set and Extract Unit

This block is a registered 32-bit field engine. Each accepted request applies one of four operations to the data word `src2`. It can zero a contiguous field, fill a field with ones, pull a field out with sign extension, or pull a field out with zero extension. Two 5-bit positions, `pos_a` and `pos_b`, steer the operation. For clear and set they bound the field: `pos_a` is its lowest bit and `pos_b` its highest. For the two extract operations the same two values act as a left-shift amount followed by a right-shift amount.

The positions come either from two immediate ports or from the low ten bits of a second operand word `src1`, as chosen by `use_reg`. In the register form, any set bit above those ten bits marks the request as malformed. The result is still produced from the low ten bits, and a flag reports the problem in the same cycle as the result. Results and flags appear one clock after the request.

Top module: `bitfield_unit`

## Requirements
- R1: When `use_reg` is 1, `pos_b` is taken from `src1[4:0]` and `pos_a` from `src1[9:5]`. When `use_reg` is 0, they are taken from `imm_b` and `imm_a`.
- R2: With `op` = 0 (clear) and `pos_b` >= `pos_a`, bits `pos_a` through `pos_b` inclusive of `dst` are 0 and every other bit equals `src2`. This includes the single-bit case `pos_a` = `pos_b`.
- R3: With `op` = 1 (set) and `pos_b` >= `pos_a`, bits `pos_a` through `pos_b` inclusive of `dst` are 1 and every other bit equals `src2`.
- R4: For clear or set with `pos_b` < `pos_a`, `dst` equals `src2` unchanged.
- R5: With `op` = 2 (signed extract), `dst` is `src2` shifted left by `pos_a`, then shifted right arithmetically by `pos_b`. For example, `pos_a` = 12 and `pos_b` = 23 yield bits 19..11 sign-extended.
- R6: With `op` = 3 (unsigned extract), the same shift pair is applied, but the right shift is logical.
- R7: `bad_operand` is 1 for an accepted register-form request whose `src1[31:10]` is nonzero, and 0 otherwise. It applies to every op.
- R8: `out_valid` is `in_valid` delayed by one clock, and `dst` and `bad_operand` belong to the request accepted at that edge.
- R9: While `in_valid` is 0, `dst` and `bad_operand` hold their previous values.
- R10: While `rst_n` is low, `dst`, `out_valid` and `bad_operand` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request accepted this cycle |
| op | input | 2 | 0 clear, 1 set, 2 signed extract, 3 unsigned extract |
| use_reg | input | 1 | 1: positions from `src1`; 0: from immediates |
| imm_a | input | 5 | Immediate field LSB / left-shift amount |
| imm_b | input | 5 | Immediate field MSB / right-shift amount |
| src1 | input | 32 | Position word for the register form |
| src2 | input | 32 | Data word operated on |
| dst | output | 32 | Result |
| out_valid | output | 1 | Result valid |
| bad_operand | output | 1 | Register-form position word had high bits set |

## Verification
The malformed-operand flag and a normal result can both occur in the same cycle. A register-form request whose `src1` carries stray high bits must still produce the operation defined by its low ten bits, alongside a raised flag. The bench provokes this for an extract and for a clear, with bit 31 or bit 10 of `src1` set. It judges `dst` against a model that uses only the low ten bits and expects `bad_operand` to be 1 in that same output cycle. A following clean request is then checked to confirm that the flag drops.

// File: rtl/bitfield_pkg.sv
package bitfield_pkg;
  typedef enum logic [1:0] {
    BF_CLEAR = 2'd0,
    BF_SET   = 2'd1,
    BF_SEXT  = 2'd2,
    BF_ZEXT  = 2'd3
  } bf_op_e;
endpackage

// File: rtl/bitfield_pos_sel.sv
module bitfield_pos_sel #(
  parameter int W     = 32,
  parameter int POS_W = 5
) (
  input  logic             use_reg,
  input  logic [POS_W-1:0] imm_a,
  input  logic [POS_W-1:0] imm_b,
  input  logic [W-1:0]     src1,
  output logic [POS_W-1:0] pos_a,
  output logic [POS_W-1:0] pos_b,
  output logic             stray
);
  localparam int SEL_W = 2 * POS_W;

  always_comb begin
    if (use_reg) begin
      pos_b = src1[POS_W-1:0];
      pos_a = src1[SEL_W-1:POS_W];
      stray = |src1[W-1:SEL_W];
    end else begin
      pos_b = imm_b;
      pos_a = imm_a;
      stray = 1'b0;
    end
  end
endmodule

// File: rtl/bitfield_mask.sv
module bitfield_mask #(
  parameter int W     = 32,
  parameter int POS_W = 5
) (
  input  logic [POS_W-1:0] lo,
  input  logic [POS_W-1:0] hi,
  output logic [W-1:0]     mask
);
  logic ordered;
  assign ordered = (hi >= lo);

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic [POS_W-1:0] IDX = POS_W'(i);
    assign mask[i] = ordered && (IDX >= lo) && (IDX <= hi);
  end
endmodule

// File: rtl/bitfield_extract.sv
module bitfield_extract #(
  parameter int W     = 32,
  parameter int POS_W = 5
) (
  input  logic [W-1:0]     data,
  input  logic [POS_W-1:0] shl,
  input  logic [POS_W-1:0] shr,
  input  logic             signed_mode,
  output logic [W-1:0]     result
);
  logic [W-1:0] left;

  always_comb begin
    left = data << shl;
    if (signed_mode) result = W'($signed(left) >>> shr);
    else             result = left >> shr;
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [1:0]   op,
  input  logic         use_reg,
  input  logic [4:0]   imm_a,
  input  logic [4:0]   imm_b,
  input  logic [31:0]  src1,
  input  logic [31:0]  src2,
  output logic [31:0]  dst,
  output logic         out_valid,
  output logic         bad_operand
);
  import bitfield_pkg::*;
  localparam int POS_W = $clog2(W);

  logic [POS_W-1:0] pos_a, pos_b;
  logic             stray;
  logic [W-1:0]     mask, ext_res;
  logic [W-1:0]     dst_d;
  logic             bad_d;
  bf_op_e           op_e;

  assign op_e = bf_op_e'(op);

  bitfield_pos_sel #(.W(W), .POS_W(POS_W)) u_sel (
    .use_reg(use_reg), .imm_a(imm_a), .imm_b(imm_b), .src1(src1),
    .pos_a(pos_a), .pos_b(pos_b), .stray(stray)
  );

  bitfield_mask #(.W(W), .POS_W(POS_W)) u_mask (
    .lo(pos_a), .hi(pos_b), .mask(mask)
  );

  bitfield_extract #(.W(W), .POS_W(POS_W)) u_ext (
    .data(src2), .shl(pos_a), .shr(pos_b),
    .signed_mode(op_e == BF_SEXT), .result(ext_res)
  );

  // next-state
  always_comb begin
    unique case (op_e)
      BF_CLEAR: dst_d = src2 & ~mask;
      BF_SET:   dst_d = src2 | mask;
      default:  dst_d = ext_res;
    endcase
    bad_d = stray;
  end

  // registers; in_valid is the clock enable for the result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst         <= '0;
      bad_operand <= 1'b0;
      out_valid   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dst         <= dst_d;
        bad_operand <= bad_d;
      end
    end
  end
endmodule

// File: rtl/bitfield_unit_chk.sv
module bitfield_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  op,
  input logic        use_reg,
  input logic [31:0] src1,
  input logic [31:0] src2,
  input logic [31:0] dst,
  input logic        out_valid,
  input logic        bad_operand
);
  // R8
  a_r8_valid_rises: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r8_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R9
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(dst) && $stable(bad_operand)));
  // R7
  a_r7_imm_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !use_reg) |=> !bad_operand);
  a_r7_reg_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && use_reg && (src1[31:10] != 22'd0)) |=> bad_operand);
  // R2
  a_r2_clear_no_new_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd0) |=> ((dst & ~$past(src2)) == 32'd0));
  // R3
  a_r3_set_no_lost_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd1) |=> ((~dst & $past(src2)) == 32'd0));
  // R10
  always @(posedge clk)
    if (!rst_n) a_r10_reset: assert (!out_valid && !bad_operand && dst == 32'd0);
endmodule

bind bitfield_unit bitfield_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .use_reg(use_reg),
  .src1(src1), .src2(src2), .dst(dst), .out_valid(out_valid),
  .bad_operand(bad_operand)
);

// File: tb/bitfield_unit_test.sv
module bitfield_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  op;
  logic        use_reg;
  logic [4:0]  imm_a, imm_b;
  logic [31:0] src1, src2;
  logic [31:0] dst;
  logic        out_valid, bad_operand;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10ns clk = ~clk;

  bitfield_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .use_reg(use_reg),
    .imm_a(imm_a), .imm_b(imm_b), .src1(src1), .src2(src2),
    .dst(dst), .out_valid(out_valid), .bad_operand(bad_operand)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [31:0] model(input logic [1:0] o, input logic [4:0] a,
                                        input logic [4:0] b, input logic [31:0] d);
    logic [31:0] r, sh;
    r = d;
    case (o)
      2'd0, 2'd1:
        for (int i = 0; i < 32; i++)
          if (b >= a && i >= a && i <= b) r[i] = o[0];
      default: begin
        sh = d << a;
        if (o == 2'd2) r = 32'($signed(sh) >>> b);
        else           r = sh >> b;
      end
    endcase
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive at negedge, result registered at next posedge, sampled at following negedge
  task automatic issue(input string tag, input logic [1:0] o, input logic ur,
                       input logic [4:0] a, input logic [4:0] b,
                       input logic [31:0] s1, input logic [31:0] s2,
                       input logic [31:0] exp, input logic exp_bad);
    in_valid = 1'b1; op = o; use_reg = ur; imm_a = a; imm_b = b; src1 = s1; src2 = s2;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " dst"}, dst, exp);
    chk({tag, " bad"}, {31'd0, bad_operand}, {31'd0, exp_bad});
    chk({tag, " valid"}, {31'd0, out_valid}, 32'd1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; op = 2'd0; use_reg = 1'b0;
    imm_a = '0; imm_b = '0; src1 = '0; src2 = '0;
    repeat (3) @(negedge clk);
    chk("R10 dst", dst, 32'd0);
    chk("R10 flags", {30'd0, out_valid, bad_operand}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_clear_set;
    issue("R2 clear mid", 2'd0, 1'b0, 5'd4, 5'd11, 32'h0, 32'hFFFF_FFFF,
          32'hFFFF_F00F, 1'b0);
    issue("R2 clear single", 2'd0, 1'b0, 5'd31, 5'd31, 32'h0, 32'hFFFF_FFFF,
          32'h7FFF_FFFF, 1'b0);
    issue("R2 clear all", 2'd0, 1'b0, 5'd0, 5'd31, 32'h0, 32'hA5A5_5A5A,
          32'h0, 1'b0);
    issue("R3 set mid", 2'd1, 1'b0, 5'd8, 5'd15, 32'h0, 32'h1234_0000,
          32'h1234_FF00, 1'b0);
    issue("R3 set single", 2'd1, 1'b0, 5'd0, 5'd0, 32'h0, 32'h0, 32'h1, 1'b0);
    issue("R4 clear reversed", 2'd0, 1'b0, 5'd20, 5'd3, 32'h0, 32'hDEAD_BEEF,
          32'hDEAD_BEEF, 1'b0);
    issue("R4 set reversed", 2'd1, 1'b0, 5'd9, 5'd8, 32'h0, 32'h0000_0000,
          32'h0, 1'b0);
  endtask

  task automatic t_extract;
    issue("R5 sext example", 2'd2, 1'b0, 5'd12, 5'd23, 32'h0, 32'h000F_F800,
          32'hFFFF_FFFF, 1'b0);
    issue("R6 zext example", 2'd3, 1'b0, 5'd12, 5'd23, 32'h0, 32'h000F_F800,
          32'h0000_01FF, 1'b0);
    issue("R5 sext positive", 2'd2, 1'b0, 5'd12, 5'd23, 32'h0, 32'h0007_0800,
          model(2'd2, 5'd12, 5'd23, 32'h0007_0800), 1'b0);
    issue("R6 zext top byte", 2'd3, 1'b0, 5'd0, 5'd24, 32'h0, 32'hC312_3456,
          32'h0000_00C3, 1'b0);
    issue("R5 sext top byte", 2'd2, 1'b0, 5'd0, 5'd24, 32'h0, 32'hC312_3456,
          32'hFFFF_FFC3, 1'b0);
  endtask

  task automatic t_register_form;
    // R1: src1[9:5]=a, src1[4:0]=b
    issue("R1 reg clear", 2'd0, 1'b1, 5'd0, 5'd0, {22'd0, 5'd16, 5'd23},
          32'hFFFF_FFFF, 32'hFF00_FFFF, 1'b0);
    issue("R1 reg zext", 2'd3, 1'b1, 5'd31, 5'd0, {22'd0, 5'd12, 5'd23},
          32'h000F_F800, 32'h0000_01FF, 1'b0);
    // R7: stray high bits flag in the same cycle as the result
    issue("R7 stray bit31 sext", 2'd2, 1'b1, 5'd0, 5'd0,
          {1'b1, 21'd0, 5'd12, 5'd23}, 32'h000F_F800, 32'hFFFF_FFFF, 1'b1);
    issue("R7 stray bit10 clear", 2'd0, 1'b1, 5'd0, 5'd0,
          {21'd0, 1'b1, 5'd0, 5'd3}, 32'h0000_00FF, 32'h0000_00F0, 1'b1);
    issue("R7 clean after", 2'd1, 1'b1, 5'd0, 5'd0, {22'd0, 5'd0, 5'd1},
          32'h0, 32'h3, 1'b0);
    issue("R7 imm ignores src1", 2'd1, 1'b0, 5'd2, 5'd2, 32'hFFFF_FFFF,
          32'h0, 32'h4, 1'b0);
  endtask

  task automatic t_hold;
    issue("R8 setup", 2'd2, 1'b1, 5'd0, 5'd0, {1'b1, 21'd0, 5'd0, 5'd4},
          32'h8000_0000, 32'hF800_0000, 1'b1);
    op = 2'd1; use_reg = 1'b0; src2 = 32'h0; imm_a = 5'd0; imm_b = 5'd31;
    @(negedge clk);
    chk("R8 idle valid", {31'd0, out_valid}, 32'd0);
    chk("R9 hold dst", dst, 32'hF800_0000);
    chk("R9 hold bad", {31'd0, bad_operand}, 32'd1);
    @(negedge clk);
    chk("R9 hold dst 2", dst, 32'hF800_0000);
  endtask

  initial begin
    t_reset();
    t_clear_set();
    t_extract();
    t_register_form();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule